// File: doc/BRIEF.md
# Ordering-Table Clear DMA Engine

This engine prepares an empty depth-sorted pointer table in main memory without any processor stores. Software loads a start address and an entry count, then writes a fixed start command to the control register. The engine then issues one word write per granted memory cycle, walking downward from the start address. Every word it writes points to the word just beneath it, so a consumer that begins at the start address walks the whole table toward lower addresses. The lowest word written holds an all-ones terminator instead of a pointer.

The walk ends after the requested number of entries or when it reaches the configured floor of main memory, whichever comes first. A fixed delay after the last accepted write, the engine pulses its interrupt for one cycle and clears the enable and trigger bits of its control register. A control write that sets the enable bit with any value other than the start command, or a start with an address below the floor, writes nothing and interrupts on the next cycle.

Top module: `otc_clear_dma`

## Requirements
- R1: After reset, all three registers read zero, `mem_req_o` is low and `irq_o` is low.
- R2: Selector 0 is the address register (ADDR_W bits, read back zero-extended), selector 1 the count register (its low CNT_W bits only are kept and read back), selector 2 the 32-bit control register; selector 3 reads zero. Writing 0x11000002 to control while idle starts a clear at the address register with its two low bits forced to zero.
- R3: Entries are written at strictly descending word addresses, starting at the aligned start address and stepping by 4; each non-final entry at address A holds A-4 in its low 24 bits and zero above. One write completes per cycle in which `mem_req_o` and `mem_gnt_i` are both high.
- R4: The final entry holds 0x00FFFFFF. A count of N writes N entries; a count of zero writes one entry, the terminator, at the start address.
- R5: No write goes below MEM_FLOOR; if the walk reaches the word at MEM_FLOOR, that word receives the terminator and the walk ends.
- R6: While `mem_req_o` is high and `mem_gnt_i` low, address and data hold steady in the next cycle.
- R7: `irq_o` is a one-cycle pulse exactly IRQ_DELAY (16) cycles after the cycle of the last accepted write, and is never high while `mem_req_o` is high.
- R8: From the cycle after the interrupt pulse, control bits 24 and 28 read zero while the other control bits keep their written value.
- R9: A control write with bit 24 set and a value other than 0x11000002, or the start command with an aligned start address below MEM_FLOOR, performs no memory write and pulses `irq_o` in the next cycle.
- R10: A control write with bit 24 clear is stored and read back, with no memory write and no interrupt.
- R11: From a start until the interrupt cycle inclusive, control writes are ignored; address and count writes update their readback but do not alter the clear in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| reg_we_i | input | 1 | Register write strobe |
| reg_sel_i | input | 2 | Register selector |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Read data of the selected register |
| mem_req_o | output | 1 | Memory write request |
| mem_gnt_i | input | 1 | Memory grant; a write completes when request and grant are high |
| mem_addr_o | output | ADDR_W | Byte address of the word being written |
| mem_wdata_o | output | DATA_W | Word being written |
| irq_o | output | 1 | Completion interrupt pulse |

## Verification
The hardest case to reach is the floor cutting a walk short while the memory grant stalls, since the terminator must then move from the count-derived position to the floor word and the interrupt must still be timed from a stalled final handshake. The bench sweeps every count of a 5-bit count field against start addresses placed at, just above and well above a nonzero floor, rotating three grant patterns across runs so that truncated walks coincide with held requests. Control writes injected mid-walk and misaligned start addresses cover the ignore and alignment rules.

// File: rtl/otc_pkg.sv
package otc_pkg;
  localparam logic [31:0] OTC_START_CMD = 32'h1100_0002;
  localparam int unsigned OTC_EN_BIT    = 24;
  localparam int unsigned OTC_TRIG_BIT  = 28;

  typedef enum logic [1:0] {
    SEL_ADDR = 2'd0,
    SEL_CNT  = 2'd1,
    SEL_CTRL = 2'd2,
    SEL_NONE = 2'd3
  } reg_sel_e;

  typedef enum logic [1:0] {
    TMR_IDLE = 2'd0,
    TMR_WAIT = 2'd1,
    TMR_FIRE = 2'd2
  } tmr_state_e;
endpackage

// File: rtl/otc_regs.sv
module otc_regs
  import otc_pkg::*;
#(
  parameter int unsigned ADDR_W    = 24,
  parameter int unsigned CNT_W     = 16,
  parameter int unsigned MEM_FLOOR = 0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [1:0]        sel_i,
  input  logic [31:0]       wdata_i,
  output logic [31:0]       rdata_o,
  input  logic              busy_i,
  input  logic              irq_i,
  output logic              start_o,
  output logic              abort_o,
  output logic [ADDR_W-1:0] start_addr_o,
  output logic [CNT_W-1:0]  count_o
);
  localparam logic [ADDR_W-1:0] FLOOR_A = ADDR_W'(MEM_FLOOR);

  logic [ADDR_W-1:0] addr_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [31:0]       ctrl_q;
  logic              ctrl_wr, trig;
  logic [ADDR_W:0]   floor_gap;
  logic              below_floor;

  assign start_addr_o = {addr_q[ADDR_W-1:2], 2'b00};
  assign count_o      = cnt_q;

  assign floor_gap   = {1'b0, start_addr_o} - {1'b0, FLOOR_A};
  assign below_floor = floor_gap[ADDR_W];

  assign ctrl_wr = we_i && (reg_sel_e'(sel_i) == SEL_CTRL) && !busy_i;
  assign trig    = ctrl_wr && wdata_i[OTC_EN_BIT];
  assign start_o = trig && (wdata_i == OTC_START_CMD) && !below_floor;
  assign abort_o = trig && !start_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_q <= '0;
      cnt_q  <= '0;
      ctrl_q <= '0;
    end else begin
      if (we_i && reg_sel_e'(sel_i) == SEL_ADDR) addr_q <= wdata_i[ADDR_W-1:0];
      if (we_i && reg_sel_e'(sel_i) == SEL_CNT)  cnt_q  <= wdata_i[CNT_W-1:0];
      if (irq_i) begin
        ctrl_q[OTC_EN_BIT]   <= 1'b0;
        ctrl_q[OTC_TRIG_BIT] <= 1'b0;
      end else if (ctrl_wr) begin
        ctrl_q <= wdata_i;
      end
    end
  end

  always_comb begin
    unique case (reg_sel_e'(sel_i))
      SEL_ADDR: rdata_o = 32'(addr_q);
      SEL_CNT:  rdata_o = 32'(cnt_q);
      SEL_CTRL: rdata_o = ctrl_q;
      default:  rdata_o = '0;
    endcase
  end

  // R8: interrupt leaves enable and trigger bits clear
  assert_ctrl_cleared_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_i |=> (!ctrl_q[OTC_EN_BIT] && !ctrl_q[OTC_TRIG_BIT]));

  // R11: control register frozen while busy and not completing
  assert_ctrl_frozen_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_i && !irq_i) |=> $stable(ctrl_q));
endmodule

// File: rtl/otc_walker.sv
module otc_walker #(
  parameter int unsigned ADDR_W    = 24,
  parameter int unsigned CNT_W     = 16,
  parameter int unsigned PTR_W     = 24,
  parameter int unsigned DATA_W    = 32,
  parameter int unsigned MEM_FLOOR = 0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [ADDR_W-1:0] start_addr_i,
  input  logic [CNT_W-1:0]  count_i,
  input  logic              gnt_i,
  output logic              req_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic [DATA_W-1:0] data_o,
  output logic              last_o
);
  localparam logic [ADDR_W-1:0] FLOOR_A = ADDR_W'(MEM_FLOOR);
  localparam logic [ADDR_W-1:0] STEP    = ADDR_W'(4);
  localparam logic [PTR_W-1:0]  TERM    = '1;

  logic              active_q;
  logic [ADDR_W-1:0] cur_q;
  logic [CNT_W-1:0]  rem_q;
  logic              hs, near_floor, final_entry;
  logic [PTR_W-1:0]  ptr;
  logic [ADDR_W:0]   floor_gap;

  assign hs          = active_q && gnt_i;
  assign near_floor  = (cur_q - FLOOR_A) < STEP;
  assign final_entry = (rem_q == CNT_W'(1)) || near_floor;
  assign ptr         = final_entry ? TERM : PTR_W'(cur_q - STEP);
  assign floor_gap   = {1'b0, cur_q} - {1'b0, FLOOR_A};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q <= 1'b0;
      cur_q    <= '0;
      rem_q    <= '0;
    end else if (start_i) begin
      active_q <= 1'b1;
      cur_q    <= start_addr_i;
      rem_q    <= (count_i == '0) ? CNT_W'(1) : count_i;
    end else if (hs) begin
      if (final_entry) begin
        active_q <= 1'b0;
      end else begin
        cur_q <= cur_q - STEP;
        rem_q <= rem_q - CNT_W'(1);
      end
    end
  end

  assign req_o  = active_q;
  assign addr_o = cur_q;
  assign data_o = DATA_W'(ptr);
  assign last_o = hs && final_entry;

  // R6: stalled request holds its address and data
  assert_stall_hold_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_o && !gnt_i) |=> (req_o && $stable(addr_o) && $stable(data_o)));

  // R3: a non-final accepted write moves one word down
  assert_descend_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hs && !final_entry) |=> (req_o && addr_o == $past(addr_o) - STEP));

  // R5: never request below the floor
  assert_above_floor_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_o |-> !floor_gap[ADDR_W]);

  // R4: the walk ends right after the terminator is accepted
  assert_stop_after_term_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (last_o && !start_i) |=> !req_o);
endmodule

// File: rtl/otc_done_timer.sv
module otc_done_timer
  import otc_pkg::*;
#(
  parameter int unsigned DELAY = 16
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic last_i,
  input  logic abort_i,
  output logic irq_o,
  output logic busy_o
);
  localparam int unsigned CW   = (DELAY > 2) ? $clog2(DELAY - 1) : 1;
  localparam logic [CW-1:0] LOAD = CW'(DELAY - 2);

  tmr_state_e    state_q;
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= TMR_IDLE;
      cnt_q   <= '0;
    end else begin
      unique case (state_q)
        TMR_IDLE: begin
          if (abort_i) begin
            state_q <= TMR_FIRE;
          end else if (last_i) begin
            state_q <= TMR_WAIT;
            cnt_q   <= LOAD;
          end
        end
        TMR_WAIT: begin
          if (cnt_q == '0) state_q <= TMR_FIRE;
          else             cnt_q   <= cnt_q - CW'(1);
        end
        default: state_q <= TMR_IDLE;
      endcase
    end
  end

  assign irq_o  = (state_q == TMR_FIRE);
  assign busy_o = (state_q != TMR_IDLE);

  // R7: interrupt is a single-cycle pulse
  assert_irq_pulse_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |=> !irq_o);

  // R9: a rejected command interrupts on the next cycle
  assert_abort_irq_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    abort_i |=> irq_o);
endmodule

// File: rtl/otc_clear_dma.sv
module otc_clear_dma #(
  parameter int unsigned ADDR_W    = 24,
  parameter int unsigned CNT_W     = 16,
  parameter int unsigned PTR_W     = 24,
  parameter int unsigned DATA_W    = 32,
  parameter int unsigned MEM_FLOOR = 0,
  parameter int unsigned IRQ_DELAY = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              reg_we_i,
  input  logic [1:0]        reg_sel_i,
  input  logic [31:0]       reg_wdata_i,
  output logic [31:0]       reg_rdata_o,
  output logic              mem_req_o,
  input  logic              mem_gnt_i,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [DATA_W-1:0] mem_wdata_o,
  output logic              irq_o
);
  logic              start, abort, last, tmr_busy, busy;
  logic [ADDR_W-1:0] start_addr;
  logic [CNT_W-1:0]  count;

  assign busy = mem_req_o || tmr_busy;

  otc_regs #(
    .ADDR_W   (ADDR_W),
    .CNT_W    (CNT_W),
    .MEM_FLOOR(MEM_FLOOR)
  ) u_regs (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .we_i        (reg_we_i),
    .sel_i       (reg_sel_i),
    .wdata_i     (reg_wdata_i),
    .rdata_o     (reg_rdata_o),
    .busy_i      (busy),
    .irq_i       (irq_o),
    .start_o     (start),
    .abort_o     (abort),
    .start_addr_o(start_addr),
    .count_o     (count)
  );

  otc_walker #(
    .ADDR_W   (ADDR_W),
    .CNT_W    (CNT_W),
    .PTR_W    (PTR_W),
    .DATA_W   (DATA_W),
    .MEM_FLOOR(MEM_FLOOR)
  ) u_walker (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .start_i     (start),
    .start_addr_i(start_addr),
    .count_i     (count),
    .gnt_i       (mem_gnt_i),
    .req_o       (mem_req_o),
    .addr_o      (mem_addr_o),
    .data_o      (mem_wdata_o),
    .last_o      (last)
  );

  otc_done_timer #(
    .DELAY(IRQ_DELAY)
  ) u_timer (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .last_i (last),
    .abort_i(abort),
    .irq_o  (irq_o),
    .busy_o (tmr_busy)
  );

  // R7: no interrupt while writes are still pending
  assert_irq_after_writes_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o |-> !irq_o);

  // R9: a rejected command never starts a walk
  assert_abort_no_write_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    abort |=> !mem_req_o);
endmodule

// File: tb/otc_clear_dma_bench.sv
module otc_clear_dma_bench;
  localparam int unsigned AW    = 12;
  localparam int unsigned CW    = 5;
  localparam int unsigned FLOOR = 32'h100;
  localparam int unsigned DLY   = 16;
  localparam int unsigned WORDS = 1 << (AW - 2);
  localparam logic [31:0] START = 32'h1100_0002;
  localparam logic [31:0] SENT  = 32'hDEAD_BEEF;

  logic          clk = 1'b0;
  logic          rst_ni = 1'b0;
  logic          we = 1'b0;
  logic [1:0]    sel = 2'd0;
  logic [31:0]   wdata = '0;
  logic [31:0]   rdata;
  logic          req, gnt = 1'b1;
  logic [AW-1:0] maddr;
  logic [31:0]   mdata;
  logic          irq;

  always #4 clk = ~clk;

  otc_clear_dma #(
    .ADDR_W(AW), .CNT_W(CW), .PTR_W(24), .DATA_W(32),
    .MEM_FLOOR(FLOOR), .IRQ_DELAY(DLY)
  ) u_otc_clear_dma (
    .clk_i(clk), .rst_ni(rst_ni), .reg_we_i(we), .reg_sel_i(sel),
    .reg_wdata_i(wdata), .reg_rdata_o(rdata), .mem_req_o(req),
    .mem_gnt_i(gnt), .mem_addr_o(maddr), .mem_wdata_o(mdata), .irq_o(irq)
  );

  logic [31:0] mem [WORDS];
  logic        wipe = 1'b0;
  int          cyc = 0, nwr = 0, nirq = 0, last_hs = 0, irq_cyc = 0;
  int          gmode = 0;
  int          checks = 0, errors = 0;

  always @(posedge clk) begin
    if (wipe) for (int i = 0; i < WORDS; i++) mem[i] <= SENT;
    if (req && gnt) begin
      mem[maddr[AW-1:2]] <= mdata;
      last_hs <= cyc;
      nwr <= nwr + 1;
    end
    if (irq) begin
      irq_cyc <= cyc;
      nirq <= nirq + 1;
    end
    cyc <= cyc + 1;
  end

  always @(negedge clk) begin
    case (gmode)
      0: gnt <= 1'b1;
      1: gnt <= cyc[0];
      default: gnt <= ((cyc % 5) != 2) && ((cyc % 7) != 0);
    endcase
  end

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic reg_wr(input logic [1:0] s, input logic [31:0] d, output int wcyc);
    sel = s; wdata = d; we = 1'b1;
    @(negedge clk);
    wcyc = cyc - 1;
    we = 1'b0;
  endtask

  task automatic reg_rd(input logic [1:0] s, output logic [31:0] d);
    sel = s;
    #1 d = rdata;
  endtask

  task automatic wait_irq(input int base, output bit seen);
    seen = 1'b0;
    for (int k = 0; k < 3000 && !seen; k++) begin
      @(negedge clk);
      if (nirq != base) seen = 1'b1;
    end
  endtask

  task automatic do_wipe();
    wipe = 1'b1;
    @(negedge clk);
    wipe = 1'b0;
  endtask

  // expected number of entries for an aligned start above the floor
  function automatic int exp_entries(input int al, input int cnt);
    int n, lim;
    n   = (cnt == 0) ? 1 : cnt;
    lim = (al - FLOOR) / 4 + 1;
    return (n < lim) ? n : lim;
  endfunction

  function automatic int image_errs(input int al, input int n);
    int bad = 0;
    for (int i = 0; i < WORDS; i++) begin
      int a = i * 4;
      logic [31:0] e;
      if (a <= al && a > al - 4 * n)
        e = (a == al - 4 * (n - 1)) ? 32'h00FF_FFFF : 32'(a - 4);
      else
        e = SENT;
      if (mem[i] !== e) bad++;
    end
    return bad;
  endfunction

  task automatic run_clear(input int start, input int cnt, input int mode, input bit poke);
    int wc, base_w, base_i, al, n;
    bit seen;
    logic [31:0] rd;
    gmode = mode;
    do_wipe();
    base_w = nwr;
    base_i = nirq;
    al = start & ~3;
    n  = exp_entries(al, cnt);
    reg_wr(2'd0, 32'(start), wc);
    reg_wr(2'd1, 32'(cnt) | 32'hFFE0_0000, wc);
    reg_rd(2'd1, rd);
    chk(rd == 32'(cnt), "R2 count readback masked", rd, cnt);
    reg_wr(2'd2, START, wc);
    if (poke) begin
      repeat (3) @(negedge clk);
      reg_wr(2'd2, 32'h0100_0000, wc);
      reg_wr(2'd0, 32'h0000_0FF0, wc);
      reg_wr(2'd1, 32'h0000_0003, wc);
      reg_rd(2'd0, rd);
      chk(rd == 32'h0FF0, "R11 address write during run readback", rd, 32'h0FF0);
    end
    wait_irq(base_i, seen);
    chk(seen, "R7 interrupt seen", seen, 1);
    chk(image_errs(al, n) == 0, "R3/R4/R5 memory image wrong words", image_errs(al, n), 0);
    chk(nwr - base_w == n, "R3/R6 accepted write count", nwr - base_w, n);
    chk(irq_cyc - last_hs == DLY, "R7 irq delay after last write", irq_cyc - last_hs, DLY);
    reg_rd(2'd2, rd);
    chk(rd == 32'h0000_0002, "R8/R11 control after completion", rd, 32'h2);
  endtask

  task automatic run_abort(input int start, input logic [31:0] cmd, input logic [31:0] exp_ctrl, input string tag);
    int wc, base_w, base_i;
    bit seen;
    logic [31:0] rd;
    base_w = nwr;
    base_i = nirq;
    reg_wr(2'd0, 32'(start), wc);
    reg_wr(2'd2, cmd, wc);
    wait_irq(base_i, seen);
    chk(seen && irq_cyc == wc + 1, {tag, " irq next cycle"}, irq_cyc - wc, 1);
    chk(nwr == base_w, {tag, " no memory write"}, nwr - base_w, 0);
    reg_rd(2'd2, rd);
    chk(rd == exp_ctrl, {tag, " control after abort"}, rd, exp_ctrl);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual=%0h expected=%0h", cyc, 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin : main
    logic [31:0] rd;
    int wc, base_w, base_i;
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    // R1 reset state
    reg_rd(2'd0, rd); chk(rd == 0, "R1 address reset", rd, 0);
    reg_rd(2'd1, rd); chk(rd == 0, "R1 count reset", rd, 0);
    reg_rd(2'd2, rd); chk(rd == 0, "R1 control reset", rd, 0);
    chk(!req && !irq, "R1 idle outputs", {req, irq}, 0);
    reg_wr(2'd3, 32'hFFFF_FFFF, wc);
    reg_rd(2'd3, rd); chk(rd == 0, "R2 selector 3 reads zero", rd, 0);

    // R10 non-triggering control write
    base_w = nwr; base_i = nirq;
    reg_wr(2'd2, 32'h0000_0002, wc);
    repeat (30) @(negedge clk);
    chk(nirq == base_i && nwr == base_w, "R10 no activity", nirq - base_i + nwr - base_w, 0);
    reg_rd(2'd2, rd); chk(rd == 32'h2, "R10 stored control", rd, 32'h2);

    // R9 abort paths
    run_abort(FLOOR + 32, 32'h0100_0000, 32'h0000_0000, "R9 bad command");
    run_abort(FLOOR + 32, 32'h1100_0003, 32'h0000_0003, "R9 near command");
    run_abort(FLOOR - 4, START, 32'h0000_0002, "R9 start below floor");

    // main sweep: R2 R3 R4 R5 R6 R7 R8
    begin
      int starts [5] = '{FLOOR, FLOOR + 4, FLOOR + 12, FLOOR + 'h3E, 'hFFC};
      int idx = 0;
      foreach (starts[s]) begin
        for (int c = 0; c < (1 << CW); c++) begin
          run_clear(starts[s], c, idx % 3, 1'b0);
          idx++;
        end
      end
    end

    // R11 writes during an active clear
    run_clear(FLOOR + 'h200, 20, 1, 1'b1);
    run_clear(FLOOR + 'h80, 0, 2, 1'b1);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule